// File: doc/BRIEF.md
# Pulse-Triggered JK Storage Element Emulator

This block mimics, in fully synchronous logic, a two-section JK storage element whose first section (the master) is open for the whole time a slow control line is high. The second section (the slave) picks up the master's value only when the control line drops. A fast system clock samples the control line and both information inputs. The master is open while the control line is high. Its set and clear paths are gated by the slave output: J acts only while the slave is 0, and K only while the slave is 1. The slave copies the master at the detected falling edge.

Because the master stays open for the full pulse, a short glitch on J or K during the pulse is captured and cannot be undone later in the same pulse. One flag reports a captured clear (zeros catching) and another a captured set (ones catching). A mode input removes the feedback gating so that the element behaves as a plain set/reset pair. In that mode, both inputs high at the falling edge is reported as an invalid condition. The state is then held, so behaviour stays deterministic.

The controller is a two-state machine. PH_LOW means the control line is low. The transition PH_LOW to PH_HIGH is taken when the synchronized control line is seen high, and PH_HIGH to PH_LOW when it is seen low. The master is enabled on every cycle in which the synchronized control line is 1. The transfer to the slave happens on the PH_HIGH to PH_LOW transition.

Top module: `pulse_jk_emu`

## Requirements
- R1: A synchronous active-high `rst` clears the element: after the reset clock, `q` = 0, `q_n` = 1 and all three flags are 0.
- R2: `q_n` is always the inverse of `q`.
- R3: `q` changes only in the cycle after a detected falling edge of the synchronized control line. While the control line is high, `q` keeps its value.
- R4: With `mode_sr` = 0, J=1 K=0 held through a pulse gives `q` = 1, J=0 K=1 gives `q` = 0, and J=K=0 leaves `q` unchanged.
- R5: With `mode_sr` = 0, J=K=1 held through a pulse inverts `q`.
- R6: Zeros catching. With `mode_sr` = 0 and `q` = 1, a K=1 glitch of any length during the pulse makes `q` become 0 at the falling edge, even if J=1 and K=0 when the line falls. `zero_catch` is high for exactly one cycle, together with the new `q`, whenever the transferred 0 differs from what the J and K values at the fall alone would give (set for 10, clear for 01, hold for 00, invert for 11).
- R7: Ones catching. With `mode_sr` = 0 and `q` = 0, a J=1 glitch during the pulse makes `q` become 1 at the falling edge, even if K=1 when the line falls. `one_catch` is high for one cycle under the same comparison rule. At most one of the three flags is high in any cycle.
- R8: With `mode_sr` = 1 there is no feedback. S (`j_in`) alone sets the master, R (`k_in`) alone clears it, and the master follows the latest input during the pulse. The result reaches `q` at the falling edge, no repeated pulse inverts `q`, and the catch flags stay 0.
- R9: With `mode_sr` = 1, if S=R=1 at the falling edge, `sr_invalid` is high for one cycle and `q` keeps its previous value.
- R10: `ctl_in`, `j_in` and `k_in` each pass through two synchronizing flops. `q` takes its new value right after the third rising clock edge that samples `ctl_in` low following a pulse, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the control line |
| rst | input | 1 | Synchronous active-high reset |
| mode_sr | input | 1 | 0: JK with feedback gating; 1: plain set/reset |
| ctl_in | input | 1 | Asynchronous slow control line (pulse) |
| j_in | input | 1 | J / S information input, asynchronous |
| k_in | input | 1 | K / R information input, asynchronous |
| q | output | 1 | Slave output |
| q_n | output | 1 | Inverted slave output |
| zero_catch | output | 1 | One-cycle pulse: a clear was captured during the pulse |
| one_catch | output | 1 | One-cycle pulse: a set was captured during the pulse |
| sr_invalid | output | 1 | One-cycle pulse: S=R=1 at the fall in set/reset mode |

## Verification
The assertions assume that `mode_sr` is static between resets. They also assume that the control line stays low for at least two clocks between pulses, so that a transfer never occurs in two consecutive cycles. The stimulus changes `mode_sr` only while `rst` is held. It keeps each pulse and each gap several clocks long and drives J and K glitches of one clock inside a pulse. J and K are kept steady from the falling edge until the transfer is complete, so the value "at the instant C fell" is well defined after synchronization.

// File: rtl/pjk_pkg.sv
package pjk_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    // Result an ideal edge-sampled JK element would produce
    function automatic logic jk_ideal(input logic j, input logic k, input logic cur);
        logic res;
        unique case ({j, k})
            2'b10:   res = 1'b1;
            2'b01:   res = 1'b0;
            2'b11:   res = ~cur;
            default: res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pjk_sync.sv
module pjk_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/pjk_ctrl.sv
module pjk_ctrl
    import pjk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_s,
    output logic en_master,
    output logic xfer
);
    phase_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_LOW;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        en_master = 1'b0;
        xfer      = 1'b0;
        unique case (state)
            PH_LOW: begin
                en_master = ctl_s;
                if (ctl_s) begin
                    state_nx = PH_HIGH;
                end
            end
            PH_HIGH: begin
                en_master = ctl_s;
                if (!ctl_s) begin
                    state_nx = PH_LOW;
                    xfer     = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/pjk_cell.sv
module pjk_cell
    import pjk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_sr,
    input  logic en_master,
    input  logic xfer,
    input  logic j,
    input  logic k,
    output logic q,
    output logic zero_catch,
    output logic one_catch,
    output logic sr_invalid
);
    logic master_r, slave_r;
    logic set_g, clr_g, master_d;
    logic ideal, bad_sr, mismatch;

    always_comb begin
        if (mode_sr) begin
            set_g = j & ~k;
            clr_g = k & ~j;
        end else begin
            set_g = j & ~slave_r;
            clr_g = k & slave_r;
        end

        master_d = master_r;
        if (en_master) begin
            if (set_g) begin
                master_d = 1'b1;
            end else if (clr_g) begin
                master_d = 1'b0;
            end
        end

        ideal    = jk_ideal(j, k, slave_r);
        bad_sr   = xfer & mode_sr & j & k;
        mismatch = xfer & ~mode_sr & (master_r != ideal);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            master_r   <= 1'b0;
            slave_r    <= 1'b0;
            zero_catch <= 1'b0;
            one_catch  <= 1'b0;
            sr_invalid <= 1'b0;
        end else begin
            master_r   <= master_d;
            zero_catch <= mismatch & ~master_r;
            one_catch  <= mismatch & master_r;
            sr_invalid <= bad_sr;
            if (bad_sr) begin
                master_r <= slave_r;
            end else if (xfer) begin
                slave_r <= master_r;
            end
        end
    end

    assign q = slave_r;
endmodule

// File: rtl/pulse_jk_emu.sv
module pulse_jk_emu #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_sr,
    input  logic ctl_in,
    input  logic j_in,
    input  logic k_in,
    output logic q,
    output logic q_n,
    output logic zero_catch,
    output logic one_catch,
    output logic sr_invalid
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw_in, syn_out;
    logic            ctl_s, j_s, k_s;
    logic            en_master, xfer;

    assign raw_in = {ctl_in, j_in, k_in};
    assign {ctl_s, j_s, k_s} = syn_out;

    pjk_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_out)
    );

    pjk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_s     (ctl_s),
        .en_master (en_master),
        .xfer      (xfer)
    );

    pjk_cell u_cell (
        .clk        (clk),
        .rst        (rst),
        .mode_sr    (mode_sr),
        .en_master  (en_master),
        .xfer       (xfer),
        .j          (j_s),
        .k          (k_s),
        .q          (q),
        .zero_catch (zero_catch),
        .one_catch  (one_catch),
        .sr_invalid (sr_invalid)
    );

    assign q_n = ~q;
endmodule

// File: rtl/pjk_chk.sv
module pjk_chk (
    input logic clk,
    input logic rst,
    input logic mode_sr,
    input logic xfer,
    input logic q,
    input logic q_n,
    input logic zero_catch,
    input logic one_catch,
    input logic sr_invalid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!q && q_n && !zero_catch && !one_catch && !sr_invalid));

    // R3
    q_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (q != $past(q))) |-> $past(xfer));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({zero_catch, one_catch, sr_invalid}));

    // R6
    zero_catch_value_chk: assert property (@(posedge clk) disable iff (rst)
        zero_catch |-> (!q && !mode_sr));

    // R7
    one_catch_value_chk: assert property (@(posedge clk) disable iff (rst)
        one_catch |-> (q && !mode_sr));

    // R6
    zero_catch_single_chk: assert property (@(posedge clk) disable iff (rst)
        zero_catch |=> !zero_catch);

    // R9
    sr_invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sr_invalid && !$past(rst)) |-> (mode_sr && q == $past(q)));

    // R8
    sr_no_catch_chk: assert property (@(posedge clk) disable iff (rst)
        mode_sr |-> (!zero_catch && !one_catch));
endmodule

bind pulse_jk_emu pjk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sr    (mode_sr),
    .xfer       (xfer),
    .q          (q),
    .q_n        (q_n),
    .zero_catch (zero_catch),
    .one_catch  (one_catch),
    .sr_invalid (sr_invalid)
);

// File: tb/pulse_jk_emu_tb.sv
module pulse_jk_emu_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sr = 1'b0;
    logic ctl = 1'b0, jv = 1'b0, kv = 1'b0;
    logic q, q_n, zero_catch, one_catch, sr_invalid;

    int checks = 0, errors = 0;
    int zc_seen = 0, oc_seen = 0, inv_seen = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    pulse_jk_emu u_dut (
        .clk(clk), .rst(rst), .mode_sr(mode_sr),
        .ctl_in(ctl), .j_in(jv), .k_in(kv),
        .q(q), .q_n(q_n), .zero_catch(zero_catch),
        .one_catch(one_catch), .sr_invalid(sr_invalid)
    );

    // behavioural reference
    bit [2:0] hist[$];
    bit cc, jj, kk, m_prev, m_mst, m_slv, m_zc, m_oc, m_inv, m_ideal;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            hist.delete();
            m_prev = 0; m_mst = 0; m_slv = 0;
            m_zc = 0; m_oc = 0; m_inv = 0;
        end else begin
            if (hist.size() == 2) begin
                {cc, jj, kk} = hist.pop_front();
            end else begin
                {cc, jj, kk} = 3'b000;
            end
            hist.push_back({ctl, jv, kv});
            m_zc = 0; m_oc = 0; m_inv = 0;
            if (cc) begin
                if (mode_sr) begin
                    if (jj && !kk) m_mst = 1;
                    else if (kk && !jj) m_mst = 0;
                end else begin
                    if (jj && !m_slv) m_mst = 1;
                    if (kk && m_slv) m_mst = 0;
                end
            end
            if (m_prev && !cc) begin
                if (mode_sr && jj && kk) begin
                    m_inv = 1;
                    m_mst = m_slv;
                end else begin
                    if (!mode_sr) begin
                        if (jj && !kk) m_ideal = 1;
                        else if (kk && !jj) m_ideal = 0;
                        else if (jj && kk) m_ideal = !m_slv;
                        else m_ideal = m_slv;
                        if (m_mst != m_ideal) begin
                            if (m_mst) m_oc = 1; else m_zc = 1;
                        end
                    end
                    m_slv = m_mst;
                end
            end
            m_prev = cc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 q vs model", q, m_slv);
            chk("R2 q_n inverse", q_n, !q);
            chk("R6 zero_catch vs model", zero_catch, m_zc);
            chk("R7 one_catch vs model", one_catch, m_oc);
            chk("R9 sr_invalid vs model", sr_invalid, m_inv);
            if (zero_catch) zc_seen++;
            if (one_catch) oc_seen++;
            if (sr_invalid) inv_seen++;
        end
    end

    task automatic do_reset(input bit sr);
        @(negedge clk);
        rst = 1; mode_sr = sr; ctl = 0; jv = 0; kv = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        zc_seen = 0; oc_seen = 0; inv_seen = 0;
    endtask

    task automatic pulse(input bit jh, input bit kh, input int hi);
        logic q0;
        @(negedge clk);
        q0 = q;
        jv = jh; kv = kh; ctl = 1;
        repeat (hi) @(negedge clk);
        chk("R3 q held during pulse", q, q0);
        ctl = 0;
        repeat (8) @(negedge clk);
        jv = 0; kv = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset(0);
        // R1
        chk("R1 q after reset", q, 0);
        chk("R1 q_n after reset", q_n, 1);
        chk("R1 flags after reset", {zero_catch, one_catch, sr_invalid}, 0);

        // R4
        pulse(1, 0, 6);  chk("R4 set", q, 1);
        pulse(0, 0, 6);  chk("R4 hold", q, 1);
        pulse(0, 1, 6);  chk("R4 reset", q, 0);
        pulse(0, 0, 5);  chk("R4 hold low", q, 0);

        // R5
        pulse(1, 1, 6);  chk("R5 toggle 1", q, 1);
        pulse(1, 1, 4);  chk("R5 toggle 2", q, 0);
        pulse(1, 1, 7);  chk("R5 toggle 3", q, 1);

        // R6 zeros catching, q = 1 now
        zc_seen = 0;
        @(negedge clk); ctl = 1;
        repeat (2) @(negedge clk); kv = 1;
        @(negedge clk); kv = 0;
        repeat (2) @(negedge clk); jv = 1;
        repeat (2) @(negedge clk);
        chk("R6 q held during pulse", q, 1);
        ctl = 0;
        repeat (8) @(negedge clk); jv = 0;
        repeat (3) @(negedge clk);
        chk("R6 q after zeros catch", q, 0);
        chk("R6 zero_catch pulses", zc_seen, 1);

        // R7 ones catching, q = 0 now
        oc_seen = 0;
        @(negedge clk); ctl = 1;
        repeat (2) @(negedge clk); jv = 1;
        @(negedge clk); jv = 0;
        repeat (2) @(negedge clk); kv = 1;
        repeat (2) @(negedge clk); ctl = 0;
        repeat (8) @(negedge clk); kv = 0;
        repeat (3) @(negedge clk);
        chk("R7 q after ones catch", q, 1);
        chk("R7 one_catch pulses", oc_seen, 1);

        // R10 latency: toggle from 1 to 0
        @(negedge clk); jv = 1; kv = 1; ctl = 1;
        repeat (5) @(negedge clk);
        ctl = 0;
        repeat (2) @(negedge clk);
        chk("R10 no change after two edges", q, 1);
        @(negedge clk);
        chk("R10 change after third edge", q, 0);
        repeat (6) @(negedge clk); jv = 0; kv = 0;
        repeat (3) @(negedge clk);

        // R8 set/reset mode
        do_reset(1);
        pulse(1, 0, 6);  chk("R8 S sets", q, 1);
        pulse(1, 0, 6);  chk("R8 S again no toggle", q, 1);
        pulse(0, 1, 6);  chk("R8 R clears", q, 0);
        // S then R inside one pulse: master follows latest
        @(negedge clk); ctl = 1; jv = 1;
        repeat (2) @(negedge clk); jv = 0; kv = 1;
        repeat (3) @(negedge clk); ctl = 0;
        repeat (8) @(negedge clk); kv = 0;
        repeat (3) @(negedge clk);
        chk("R8 follows latest input", q, 0);
        chk("R8 no catch flags", zc_seen + oc_seen, 0);

        // R9 invalid with q = 1
        pulse(1, 0, 6);
        inv_seen = 0;
        pulse(1, 1, 6);
        chk("R9 q kept on invalid", q, 1);
        chk("R9 sr_invalid pulses", inv_seen, 1);
        inv_seen = 0;
        pulse(0, 0, 5);
        chk("R9 q steady after invalid", q, 1);
        chk("R9 no further invalid", inv_seen, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule